// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers a wide vector of maskable peripheral requests and a small set of non-maskable trap requests. It reduces them to one interrupt line for the processor. Along with that line it supplies the winning vector's number and the absolute program-memory address from which the processor fetches the handler pointer. Each maskable source has an enable bit and a 3-bit priority. A priority of zero keeps the source silent. Traps always outrank maskable sources and do not depend on the processor's current priority.

Requests are captured in pending flags, so a one-cycle pulse is enough. The processor answers an asserted line with a one-cycle acknowledge. That clears the served flag and lowers the line for a cycle, and the next winner is then presented. Vector numbers are unified: values 0 to 7 are trap slots and values 8 to 125 are maskable sources 0 to 117. The address is 4 plus twice the unified number, so source n sits at 0x14 + 2n.

Top module: `intc_top`

## Requirements
- R1: After reset, cpu_irq is 0, vec_num is 0 and vec_addr is 0x000000.
- R2: A single-cycle pulse on src_req[n] stays pending until that source is acknowledged.
- R3: A maskable source is presented only when its enable is 1 and its priority is strictly greater than cpu_prio. A priority of 0 never requests.
- R4: Among eligible maskable sources, the one with the highest priority value wins, whatever its index.
- R5: Among eligible sources of equal priority, the lower source index wins.
- R6: Any pending trap wins over every maskable source, regardless of cpu_prio. Among traps, the lower slot wins, and vec_is_trap is 1.
- R7: Trap slots 0, 5, 6 and 7 are reserved and never request. Slots 1 to 4 are oscillator fail, address error, stack error and math error.
- R8: vec_num is the slot number s for a trap and 8+n for source n. vec_addr is the 24-bit value 4 + 2*vec_num.
- R9: While cpu_irq is 1 and cpu_ack is 0, cpu_irq, vec_num, vec_addr and vec_is_trap hold their values, even if a stronger request arrives.
- R10: cpu_ack sampled with cpu_irq at 1 clears the served pending flag and drops cpu_irq on the next edge. The next winner appears one edge later. cpu_ack sampled while cpu_irq is 0 has no effect.
- R11: A new request from the served source, arriving in the same cycle as its acknowledge, stays pending and is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| src_req | input | 118 | Maskable request pulses, one per source |
| src_en | input | 118 | Per-source enable |
| src_prio | input | 354 | 3-bit priority per source; source n at bits [3n+2:3n] |
| trap_req | input | 8 | Trap request pulses, bit s is slot s |
| cpu_prio | input | 3 | Current processor priority |
| cpu_ack | input | 1 | One-cycle acknowledge of the presented vector |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_is_trap | output | 1 | Presented vector is a trap |
| vec_num | output | 7 | Unified vector number |
| vec_addr | output | 24 | Vector-table address of the presented vector |

## Verification
The assertions assume that cpu_ack is raised only for a single cycle and only while cpu_irq is high. They also assume that no request is driven while reset is active. The stimulus meets both conditions. Requests are driven only after reset is released. The acknowledging monitor pulses cpu_ack for exactly one cycle in answer to a visible cpu_irq. Manual acknowledges in the hold test follow the same rule. To make the arbitration order deterministic, requests are posted while cpu_prio is 7, so no maskable source can win yet. cpu_prio is lowered only after all of them are pending.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NTRAP   = 8;
    localparam int VEC_BASE = 4;
    localparam int VEC_STEP = 2;

    // absolute vector-table address of a unified vector number
    function automatic int unsigned vec_addr_of(input int unsigned num);
        return VEC_BASE + VEC_STEP * num;
    endfunction
endpackage

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int          NSRC      = 118,
    parameter int          VW        = 7,
    parameter logic [7:0]  TRAP_USED = 8'b0001_1110
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             src_req,
    input  logic [intc_pkg::NTRAP-1:0]  trap_req,
    input  logic                        clr_en,
    input  logic                        clr_trap,
    input  logic [VW-1:0]               clr_idx,
    output logic [NSRC-1:0]             src_pend,
    output logic [intc_pkg::NTRAP-1:0]  trap_pend
);
    import intc_pkg::*;

    typedef struct packed {
        logic [NSRC-1:0]  src;
        logic [NTRAP-1:0] trap;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        // clear the served flag first, then let new requests win
        for (int i = 0; i < NTRAP; i++) begin
            if (clr_en && clr_trap && clr_idx == VW'(i))
                pend_d.trap[i] = 1'b0;
        end
        for (int i = 0; i < NSRC; i++) begin
            if (clr_en && !clr_trap && clr_idx == VW'(NTRAP + i))
                pend_d.src[i] = 1'b0;
        end
        pend_d.trap = pend_d.trap | (trap_req & TRAP_USED);
        pend_d.src  = pend_d.src | src_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign src_pend  = pend_q.src;
    assign trap_pend = pend_q.trap;

    // R2, R11: every request seen on an edge is pending after it
    a_r2_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> (($past(src_req) & ~pend_q.src) == '0));

    // R7: reserved trap slots never become pending
    a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q.trap & ~TRAP_USED) == '0);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NSRC = 118,
    parameter int PW   = 3,
    parameter int VW   = 7
) (
    input  logic [NSRC-1:0]             src_pend,
    input  logic [NSRC-1:0]             src_en,
    input  logic [NSRC*PW-1:0]          src_prio,
    input  logic [intc_pkg::NTRAP-1:0]  trap_pend,
    input  logic [PW-1:0]               cpu_prio,
    output logic                        win_valid,
    output logic                        win_trap,
    output logic [VW-1:0]               win_num
);
    import intc_pkg::*;

    logic          trap_hit;
    logic [VW-1:0] trap_num;
    logic          src_hit;
    logic [VW-1:0] src_num;
    logic [PW-1:0] best_prio;

    // traps: lowest slot wins, scan downwards so the last hit is the lowest
    always_comb begin
        trap_hit = 1'b0;
        trap_num = '0;
        for (int i = NTRAP - 1; i >= 0; i--) begin
            if (trap_pend[i]) begin
                trap_hit = 1'b1;
                trap_num = VW'(i);
            end
        end
    end

    // maskable: strictly above the running best, which starts at cpu_prio;
    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        src_hit   = 1'b0;
        src_num   = '0;
        best_prio = cpu_prio;
        for (int i = 0; i < NSRC; i++) begin
            if (src_pend[i] && src_en[i] && src_prio[i*PW +: PW] > best_prio) begin
                src_hit   = 1'b1;
                src_num   = VW'(NTRAP + i);
                best_prio = src_prio[i*PW +: PW];
            end
        end
    end

    assign win_valid = trap_hit | src_hit;
    assign win_trap  = trap_hit;
    assign win_num   = trap_hit ? trap_num : src_num;
endmodule

// File: rtl/intc_top.sv
module intc_top #(
    parameter int          NSRC      = 118,
    parameter int          PW        = 3,
    parameter int          AW        = 24,
    parameter logic [7:0]  TRAP_USED = 8'b0001_1110,
    localparam int         VW        = $clog2(intc_pkg::NTRAP + NSRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             src_req,
    input  logic [NSRC-1:0]             src_en,
    input  logic [NSRC*PW-1:0]          src_prio,
    input  logic [intc_pkg::NTRAP-1:0]  trap_req,
    input  logic [PW-1:0]               cpu_prio,
    input  logic                        cpu_ack,
    output logic                        cpu_irq,
    output logic                        vec_is_trap,
    output logic [VW-1:0]               vec_num,
    output logic [AW-1:0]               vec_addr
);
    import intc_pkg::*;

    typedef struct packed {
        logic          irq;
        logic          trap;
        logic [VW-1:0] num;
        logic [AW-1:0] addr;
    } state_t;

    state_t              st_d, st_q;
    logic [NSRC-1:0]     src_pend;
    logic [NTRAP-1:0]    trap_pend;
    logic                win_valid;
    logic                win_trap;
    logic [VW-1:0]       win_num;
    logic                served;

    assign served = st_q.irq && cpu_ack;

    intc_pending #(.NSRC(NSRC), .VW(VW), .TRAP_USED(TRAP_USED)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .trap_req (trap_req),
        .clr_en   (served),
        .clr_trap (st_q.trap),
        .clr_idx  (st_q.num),
        .src_pend (src_pend),
        .trap_pend(trap_pend)
    );

    intc_arbiter #(.NSRC(NSRC), .PW(PW), .VW(VW)) u_arb (
        .src_pend (src_pend),
        .src_en   (src_en),
        .src_prio (src_prio),
        .trap_pend(trap_pend),
        .cpu_prio (cpu_prio),
        .win_valid(win_valid),
        .win_trap (win_trap),
        .win_num  (win_num)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.irq) begin
            st_d.irq = win_valid;
            if (win_valid) begin
                st_d.trap = win_trap;
                st_d.num  = win_num;
                st_d.addr = AW'(vec_addr_of(32'(win_num)));
            end
        end else if (cpu_ack) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq     = st_q.irq;
    assign vec_is_trap = st_q.trap;
    assign vec_num     = st_q.num;
    assign vec_addr    = st_q.addr;

    // R9: presented vector held until acknowledged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(vec_num) && $stable(vec_addr)));

    // R10: acknowledge drops the line for one edge
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && cpu_ack) |=> !cpu_irq);

    // R6: a pending trap is presented ahead of anything else
    a_r6_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq && trap_pend != '0) |=> (cpu_irq && vec_is_trap));

    // R3: nothing pending and enabled means no request
    a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq && trap_pend == '0 && (src_pend & src_en) == '0) |=> !cpu_irq);
endmodule

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam int  NSRC   = 118;
    localparam int  PW     = 3;
    localparam int  VW     = 7;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSRC-1:0]    src_req = '0;
    logic [NSRC-1:0]    src_en = '0;
    logic [NSRC*PW-1:0] src_prio = '0;
    logic [7:0]         trap_req = '0;
    logic [PW-1:0]      cpu_prio = 3'd7;
    logic               cpu_ack = 1'b0;
    logic               cpu_irq;
    logic               vec_is_trap;
    logic [VW-1:0]      vec_num;
    logic [23:0]        vec_addr;

    intc_top i_intc_top (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .src_prio(src_prio), .trap_req(trap_req), .cpu_prio(cpu_prio),
        .cpu_ack(cpu_ack), .cpu_irq(cpu_irq), .vec_is_trap(vec_is_trap),
        .vec_num(vec_num), .vec_addr(vec_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    trap;
        int    num;
        int    addr;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   auto_ack = 1'b1;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8: unified number and address computed from the requirement
    function automatic void push_src(input int n, input string tag);
        exp_t e;
        e.trap = 1'b0; e.num = 8 + n; e.addr = 4 + 2 * (8 + n); e.tag = tag;
        exp_q.push_back(e);
    endfunction

    function automatic void push_trap(input int s, input string tag);
        exp_t e;
        e.trap = 1'b1; e.num = s; e.addr = 4 + 2 * s; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    task automatic set_src(input int n, input bit en, input int p);
        src_en[n] = en;
        src_prio[n*PW +: PW] = PW'(p);
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // monitor: compares each presented vector and acknowledges it
    always @(negedge clk) begin
        if (auto_ack && rst_n) begin
            if (cpu_ack) begin
                cpu_ack = 1'b0;
            end else if (cpu_irq) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected vector", longint'(vec_num), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(vec_num == VW'(e.num), {e.tag, " R8 num"}, longint'(vec_num), longint'(e.num));
                    chk(vec_addr == 24'(e.addr), {e.tag, " R8 addr"}, longint'(vec_addr), longint'(e.addr));
                    chk(vec_is_trap == e.trap, {e.tag, " R6 trap flag"}, longint'(vec_is_trap), longint'(e.trap));
                end
                cpu_ack = 1'b1;
            end
        end
    end

    task automatic drain;
        while (exp_q.size() != 0) @(negedge clk);
        cyc(4);
        chk(exp_q.size() == 0 && !cpu_irq, "R10 idle after drain", longint'(cpu_irq), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : driver
        cyc(3);
        // R1: reset state
        chk(cpu_irq == 1'b0, "R1 irq", longint'(cpu_irq), 0);
        chk(vec_addr == 24'h0 && vec_num == '0, "R1 addr", longint'(vec_addr), 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 R4 R5: one-cycle pulses, mixed priorities, posted under cpu_prio 7
        set_src(10, 1, 3); set_src(3, 1, 3); set_src(100, 1, 6); set_src(117, 1, 1);
        src_req[10] = 1; src_req[3] = 1; src_req[100] = 1; src_req[117] = 1;
        cyc(1);
        src_req = '0;
        cyc(3);
        chk(!cpu_irq, "R3 blocked by cpu_prio 7", longint'(cpu_irq), 0);
        push_src(100, "R4"); push_src(3, "R5"); push_src(10, "R5 R2"); push_src(117, "R4 R2");
        cpu_prio = 3'd0;
        drain();

        // R3: priority zero and disabled sources stay silent; priority must exceed cpu_prio
        cpu_prio = 3'd2;
        set_src(20, 1, 0); set_src(21, 0, 5); set_src(22, 1, 2);
        src_req[20] = 1; src_req[21] = 1; src_req[22] = 1;
        cyc(1);
        src_req = '0;
        cyc(4);
        chk(!cpu_irq, "R3 no eligible source", longint'(cpu_irq), 0);
        push_src(22, "R3 above cpu_prio");
        cpu_prio = 3'd1;
        drain();

        // R6 R7: all trap slots plus a top-priority maskable source
        cpu_prio = 3'd7;
        set_src(50, 1, 7);
        src_req[50] = 1; trap_req = 8'hFF;
        cyc(1);
        src_req = '0; trap_req = '0;
        push_trap(1, "R6 R7 osc"); push_trap(2, "R6 addr"); push_trap(3, "R6 stack"); push_trap(4, "R6 math");
        cyc(8);
        push_src(50, "R6 after traps");
        cpu_prio = 3'd6;
        drain();

        // R9 R10 R11: manual acknowledge
        auto_ack = 1'b0;
        cpu_prio = 3'd0;
        set_src(60, 1, 2); set_src(61, 1, 7);
        src_req[60] = 1;
        cyc(1);
        src_req = '0;
        cyc(2);
        chk(cpu_irq && vec_num == VW'(68), "R9 first vector", longint'(vec_num), 68);
        src_req[61] = 1;
        cyc(1);
        src_req = '0;
        cyc(3);
        chk(cpu_irq && vec_num == VW'(68) && vec_addr == 24'd140, "R9 held", longint'(vec_num), 68);
        cpu_ack = 1'b1;
        cyc(1);
        cpu_ack = 1'b0;
        chk(!cpu_irq, "R10 dropped after ack", longint'(cpu_irq), 0);
        cyc(1);
        chk(cpu_irq && vec_num == VW'(69), "R10 next winner", longint'(vec_num), 69);
        cpu_ack = 1'b1; src_req[61] = 1;
        cyc(1);
        cpu_ack = 1'b0; src_req = '0;
        chk(!cpu_irq, "R11 drop", longint'(cpu_irq), 0);
        cyc(1);
        chk(cpu_irq && vec_num == VW'(69), "R11 re-presented", longint'(vec_num), 69);
        cpu_ack = 1'b1;
        cyc(1);
        cpu_ack = 1'b0;
        // R10: acknowledge with line low does nothing to a later request
        cpu_ack = 1'b1;
        cyc(1);
        cpu_ack = 1'b0;
        chk(!cpu_irq, "R10 stray ack", longint'(cpu_irq), 0);
        set_src(70, 1, 4);
        src_req[70] = 1;
        cyc(1);
        src_req = '0;
        cyc(1);
        chk(cpu_irq && vec_num == VW'(78) && vec_addr == 24'd160, "R10 R8 after stray ack", longint'(vec_addr), 160);
        cpu_ack = 1'b1;
        cyc(1);
        cpu_ack = 1'b0;
        cyc(3);
        chk(!cpu_irq, "R2 cleared after ack", longint'(cpu_irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule